// File: doc/BRIEF.md
# Partitioned Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations and searches all of them in parallel. Each slot carries a page-aligned virtual base, a page-size code, a partition number, a context number, a real-mode flag and a page-table word. Bit `LOCK_BIT` of that word marks the slot as locked. The other attribute bits of the word are stored as given and returned unchanged. The lookup port compares the probe against every slot in one cycle and registers hit, slot index and page-table word for the next cycle.

A single command port loads new translations and removes old ones. A load first clears every slot whose address range collides with the new one. It then writes either a slot named by the caller or a slot that the replacement logic picks from the per-slot used bits, skipping locked slots. The same port removes translations at three scopes: one page, one context, or a whole partition. It can also wipe the whole buffer. A diagnostic port reads back the tag and the page-table word of any slot by index, one cycle later.

Page size code n means a page of 8 KiB × 8^n, so the page offset has 13 + 3n bits. Command codes on `cmd_op` are: 0 idle, 1 load, 2 remove page, 3 remove context, 4 remove partition, 5 wipe.

Top module: `part_tlb`

## Requirements
- R1: A probe with `lk_valid` matches a valid slot when all of the following hold: the slot's real flag equals the probe's, the partitions are equal, the contexts are equal unless the probe is real, and the probe address with the slot's page offset cleared equals the slot base. One cycle later `lk_hit`, `lk_idx` (the lowest matching slot) and `lk_data` report the result.
- R2: A load (`cmd_op`=1) stores the base as `cmd_va` with its low 13+3·`cmd_size` bits cleared.
- R3: Before writing, a load invalidates every valid slot whose range overlaps the new range and that has the same real flag and the same partition. Slots that are not real must also have the same context to be invalidated.
- R4: A load with `cmd_use_idx`=1 writes slot `cmd_idx`. Otherwise the load writes the lowest free slot. If there is none, it writes the lowest slot whose used bit is clear and whose lock bit is clear. If there is none of those either, it writes the last slot.
- R5: A loaded slot becomes valid and used. If every used bit is then set, all used bits except that of the loaded slot are cleared.
- R6: A probe hit with `lk_update`=1 sets the hit slot's used bit, with the same all-set clearing that spares the hit slot. A probe with `lk_update`=0 leaves the used bits unchanged.
- R7: Remove-page (`cmd_op`=2) invalidates the slot that matches `cmd_va`, `cmd_part`, `cmd_ctx` and `cmd_real` under the R1 rule, and clears its used bit.
- R8: Remove-context (`cmd_op`=3) invalidates every slot whose partition and context both match, whether or not the slot is locked.
- R9: Remove-partition (`cmd_op`=4) invalidates every slot of `cmd_part` whose lock bit is clear. Locked slots are left in place.
- R10: Wipe (`cmd_op`=5) and synchronous reset clear all valid and used bits. After reset `lk_hit` is 0.
- R11: A diagnostic read of an invalid slot returns all ones on `dg_tag` and `dg_data` one cycle later. For a valid slot, `dg_tag` holds the following fields, with all other bits 0: partition at bits 63:61, real flag at bit 60, the inverted size code at bits 58:56, the base at bits VA_W-1:13, and the context at bits 12:0.
- R12: When a probe and a command fall in the same cycle, the probe reports the contents from before the command, and the probe's used-bit update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Probe request |
| lk_va | input | VA_W | Probe virtual address |
| lk_part | input | 3 | Probe partition |
| lk_ctx | input | 13 | Probe context |
| lk_real | input | 1 | Probe is a real-mode access |
| lk_update | input | 1 | Mark the hit slot as used |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R-list) |
| cmd_va | input | VA_W | Command virtual address |
| cmd_part | input | 3 | Command partition |
| cmd_ctx | input | 13 | Command context |
| cmd_real | input | 1 | Command real flag |
| cmd_size | input | 3 | Page size code for a load |
| cmd_use_idx | input | 1 | Load into `cmd_idx` instead of the chosen slot |
| cmd_idx | input | IDX_W | Explicit slot for a load |
| cmd_data | input | DATA_W | Page-table word for a load |
| dg_idx | input | IDX_W | Slot to read back |
| lk_hit | output | 1 | Registered probe hit |
| lk_idx | output | IDX_W | Registered hit slot |
| lk_data | output | DATA_W | Registered page-table word of the hit slot |
| dg_tag | output | 64 | Registered diagnostic tag |
| dg_data | output | DATA_W | Registered diagnostic page-table word |

## Verification
A probe and a command can land in the same clock, and the two then compete for the used bits. The bench provokes this in two ways. First, it loads a page in the very cycle that probes the same page, and it expects a miss, then a hit on the next probe. Second, it fills three slots and issues an updating probe of slot 0 together with a load that fills the last slot and saturates the used bits. It judges the result by the slot that the next automatic load picks: slot 0 is correct only if the probe's update was dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PART_W   = 3;
  localparam int CTX_W    = 13;
  localparam int SZ_W     = 3;
  localparam int PG_SHIFT = 13;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_LOAD     = 3'd1,
    OP_RM_PAGE  = 3'd2,
    OP_RM_CTX   = 3'd3,
    OP_RM_PART  = 3'd4,
    OP_WIPE     = 3'd5
  } tlb_op_e;

  // page offset mask for a size code: 13 + 3*code low bits set
  function automatic logic [63:0] pg_mask(input logic [SZ_W-1:0] code);
    return (64'd1 << (PG_SHIFT + 3 * int'(code))) - 64'd1;
  endfunction
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  free_v,
  input  logic [N-1:0]  used_v,
  input  logic [N-1:0]  lock_v,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  cold_v;
  logic          f_any, c_any;
  logic [IW-1:0] f_idx, c_idx;

  assign cold_v = ~used_v & ~lock_v;

  tlb_prio_enc #(.N(N), .IW(IW)) u_free (.req(free_v), .any(f_any), .idx(f_idx));
  tlb_prio_enc #(.N(N), .IW(IW)) u_cold (.req(cold_v), .any(c_any), .idx(c_idx));

  always_comb begin
    if (f_any)      idx = f_idx;
    else if (c_any) idx = c_idx;
    else            idx = IW'(N - 1);
  end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic              e_valid,
  input  logic [VA_W-1:0]   e_va,
  input  logic [SZ_W-1:0]   e_sz,
  input  logic [PART_W-1:0] e_part,
  input  logic [CTX_W-1:0]  e_ctx,
  input  logic              e_real,
  input  logic [VA_W-1:0]   l_va,
  input  logic [PART_W-1:0] l_part,
  input  logic [CTX_W-1:0]  l_ctx,
  input  logic              l_real,
  input  logic [VA_W-1:0]   c_va,
  input  logic [SZ_W-1:0]   c_sz,
  input  logic [PART_W-1:0] c_part,
  input  logic [CTX_W-1:0]  c_ctx,
  input  logic              c_real,
  output logic              lk_m,
  output logic              pg_m,
  output logic              ov_m,
  output logic              cx_m,
  output logic              pt_m
);
  logic [VA_W-1:0] e_mask, n_mask, n_base;
  logic            c_tag_ok;

  assign e_mask   = VA_W'(pg_mask(e_sz));
  assign n_mask   = VA_W'(pg_mask(c_sz));
  assign n_base   = c_va & ~n_mask;
  assign c_tag_ok = e_valid && (e_real == c_real) && (e_part == c_part) &&
                    (c_real || (e_ctx == c_ctx));

  assign lk_m = e_valid && (e_real == l_real) && (e_part == l_part) &&
                (l_real || (e_ctx == l_ctx)) && ((l_va & ~e_mask) == e_va);
  assign pg_m = c_tag_ok && ((c_va & ~e_mask) == e_va);
  // aligned power-of-8 ranges overlap iff one contains the other's base
  assign ov_m = c_tag_ok && (((n_base & ~e_mask) == e_va) ||
                             ((e_va & ~n_mask) == n_base));
  assign cx_m = e_valid && (e_part == c_part) && (e_ctx == c_ctx);
  assign pt_m = e_valid && (e_part == c_part);
endmodule

// File: rtl/part_tlb.sv
module part_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 48,
  parameter int DATA_W   = 32,
  parameter int LOCK_BIT = 0,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [PART_W-1:0] lk_part,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  input  logic              lk_update,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [PART_W-1:0] cmd_part,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_real,
  input  logic [SZ_W-1:0]   cmd_size,
  input  logic              cmd_use_idx,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [IDX_W-1:0]  dg_idx,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  output logic [63:0]       dg_tag,
  output logic [DATA_W-1:0] dg_data
);
  localparam int N = ENTRIES;

  // slot storage
  logic [VA_W-1:0]   e_va   [N];
  logic [SZ_W-1:0]   e_sz   [N];
  logic [PART_W-1:0] e_part [N];
  logic [CTX_W-1:0]  e_ctx  [N];
  logic              e_real [N];
  logic [DATA_W-1:0] e_data [N];
  logic [N-1:0]      valid_q, used_q, valid_d, used_d;

  logic [N-1:0] lk_m, pg_m, ov_m, cx_m, pt_m, lock_v;
  logic         lk_any;
  logic [IDX_W-1:0] lk_sel, vict_idx, ins_idx;
  tlb_op_e      op;
  logic         is_load;

  assign op      = tlb_op_e'(cmd_op);
  assign is_load = cmd_valid && (op == OP_LOAD);

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign lock_v[g] = e_data[g][LOCK_BIT];
    tlb_entry_cmp #(.VA_W(VA_W)) u_cmp (
      .e_valid(valid_q[g]), .e_va(e_va[g]), .e_sz(e_sz[g]),
      .e_part(e_part[g]), .e_ctx(e_ctx[g]), .e_real(e_real[g]),
      .l_va(lk_va), .l_part(lk_part), .l_ctx(lk_ctx), .l_real(lk_real),
      .c_va(cmd_va), .c_sz(cmd_size), .c_part(cmd_part), .c_ctx(cmd_ctx),
      .c_real(cmd_real),
      .lk_m(lk_m[g]), .pg_m(pg_m[g]), .ov_m(ov_m[g]), .cx_m(cx_m[g]),
      .pt_m(pt_m[g])
    );
  end

  tlb_prio_enc #(.N(N), .IW(IDX_W)) u_hit_enc (
    .req(lk_m), .any(lk_any), .idx(lk_sel)
  );

  tlb_victim #(.N(N), .IW(IDX_W)) u_victim (
    .free_v(~(valid_q & ~ov_m)), .used_v(used_q & ~ov_m), .lock_v(lock_v),
    .idx(vict_idx)
  );

  assign ins_idx = cmd_use_idx ? cmd_idx : vict_idx;

  // next valid / used state; commands win over probe updates
  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    if (cmd_valid) begin
      case (op)
        OP_LOAD: begin
          valid_d = valid_q & ~ov_m;
          used_d  = used_q & ~ov_m;
          valid_d[ins_idx] = 1'b1;
          used_d[ins_idx]  = 1'b1;
          if (&used_d) used_d = N'(1) << ins_idx;
        end
        OP_RM_PAGE: begin
          valid_d = valid_q & ~pg_m;
          used_d  = used_q & ~pg_m;
        end
        OP_RM_CTX: begin
          valid_d = valid_q & ~cx_m;
          used_d  = used_q & ~cx_m;
        end
        OP_RM_PART: begin
          valid_d = valid_q & ~(pt_m & ~lock_v);
          used_d  = used_q & ~(pt_m & ~lock_v);
        end
        OP_WIPE: begin
          valid_d = '0;
          used_d  = '0;
        end
        default: ;
      endcase
    end else if (lk_valid && lk_update && lk_any) begin
      used_d[lk_sel] = 1'b1;
      if (&used_d) used_d = N'(1) << lk_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
    end
  end

  // slot contents: no reset, written only by a load
  always_ff @(posedge clk) begin
    if (is_load) begin
      e_va[ins_idx]   <= cmd_va & ~VA_W'(pg_mask(cmd_size));
      e_sz[ins_idx]   <= cmd_size;
      e_part[ins_idx] <= cmd_part;
      e_ctx[ins_idx]  <= cmd_ctx;
      e_real[ins_idx] <= cmd_real;
      e_data[ins_idx] <= cmd_data;
    end
  end

  // registered probe result
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      lk_idx  <= '0;
      lk_data <= '0;
    end else begin
      lk_hit  <= lk_valid && lk_any;
      lk_idx  <= lk_sel;
      lk_data <= e_data[lk_sel];
    end
  end

  // diagnostic read-back
  logic        dg_ok;
  logic [63:0] tag_w;

  assign dg_ok = (int'(dg_idx) < N) && valid_q[dg_idx];

  always_comb begin
    tag_w = '0;
    tag_w[63:61] = e_part[dg_idx];
    tag_w[60]    = e_real[dg_idx];
    tag_w[58:56] = ~e_sz[dg_idx];
    tag_w[VA_W-1:PG_SHIFT] = e_va[dg_idx][VA_W-1:PG_SHIFT];
    tag_w[CTX_W-1:0] = e_ctx[dg_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dg_tag  <= '1;
      dg_data <= '1;
    end else begin
      dg_tag  <= dg_ok ? tag_w : '1;
      dg_data <= dg_ok ? e_data[dg_idx] : '1;
    end
  end

  // ---------------- assertions ----------------
  // R5
  used_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (used_q & ~valid_q) == '0);

  if (N > 1) begin : g_full_chk
    // R6
    used_not_full_chk: assert property (@(posedge clk) disable iff (rst)
      !(&used_q));
  end

  // R4
  load_sets_slot_chk: assert property (@(posedge clk) disable iff (rst)
    is_load && (int'(ins_idx) < N) |=> valid_q[$past(ins_idx)]);

  // R10
  wipe_empty_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (op == OP_WIPE) |=> valid_q == '0);

  // R9
  rm_part_lock_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (op == OP_RM_PART) |=>
      (valid_q & lock_v) == $past(valid_q & lock_v));

  // R1
  hit_needs_probe_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid));

  // R11
  dg_invalid_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q[dg_idx] |=> (dg_tag == '1) && (dg_data == '1));
endmodule

// File: tb/part_tlb_tb.sv
module part_tlb_tb;
  localparam int N  = 4;
  localparam int VW = 32;
  localparam int DW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 0, lk_real = 0, lk_update = 0;
  logic [VW-1:0] lk_va = '0;
  logic [2:0]    lk_part = '0;
  logic [12:0]   lk_ctx = '0;
  logic          cmd_valid = 0, cmd_real = 0, cmd_use_idx = 0;
  logic [2:0]    cmd_op = '0, cmd_part = '0, cmd_size = '0;
  logic [VW-1:0] cmd_va = '0;
  logic [12:0]   cmd_ctx = '0;
  logic [IW-1:0] cmd_idx = '0, dg_idx = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic [DW-1:0] lk_data, dg_data;
  logic [63:0]   dg_tag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  part_tlb #(.ENTRIES(N), .VA_W(VW), .DATA_W(DW), .LOCK_BIT(0)) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_part(lk_part), .lk_ctx(lk_ctx),
    .lk_real(lk_real), .lk_update(lk_update),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va),
    .cmd_part(cmd_part), .cmd_ctx(cmd_ctx), .cmd_real(cmd_real),
    .cmd_size(cmd_size), .cmd_use_idx(cmd_use_idx), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .dg_idx(dg_idx),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_data(lk_data),
    .dg_tag(dg_tag), .dg_data(dg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [2:0] op, input logic [VW-1:0] va,
                         input logic [2:0] part, input logic [12:0] ctx,
                         input logic rl, input logic [2:0] sz,
                         input logic [DW-1:0] d, input logic use_i,
                         input logic [IW-1:0] i);
    cmd_valid = 1; cmd_op = op; cmd_va = va; cmd_part = part; cmd_ctx = ctx;
    cmd_real = rl; cmd_size = sz; cmd_data = d; cmd_use_idx = use_i; cmd_idx = i;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [VW-1:0] va,
                        input logic [2:0] part, input logic [12:0] ctx,
                        input logic rl, input logic [2:0] sz,
                        input logic [DW-1:0] d, input logic use_i,
                        input logic [IW-1:0] i);
    @(negedge clk);
    set_cmd(op, va, part, ctx, rl, sz, d, use_i, i);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic set_lk(input logic [VW-1:0] va, input logic [2:0] part,
                        input logic [12:0] ctx, input logic rl, input logic upd);
    lk_valid = 1; lk_va = va; lk_part = part; lk_ctx = ctx; lk_real = rl;
    lk_update = upd;
  endtask

  task automatic probe(input logic [VW-1:0] va, input logic [2:0] part,
                       input logic [12:0] ctx, input logic rl, input logic upd);
    @(negedge clk);
    set_lk(va, part, ctx, rl, upd);
    @(negedge clk);
    lk_valid = 0; lk_update = 0;
  endtask

  task automatic diag(input logic [IW-1:0] i);
    @(negedge clk);
    dg_idx = i;
    @(negedge clk);
  endtask

  // probe vectors: {va, part, ctx, real, exp_hit, exp_idx}
  localparam int NV = 8;
  localparam logic [51:0] LKV [NV] = '{
    {32'h0001_2abc, 3'd1, 13'd5, 1'b0, 1'b1, 2'd0},
    {32'h0004_f123, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1},
    {32'h0001_2abc, 3'd1, 13'd6, 1'b0, 1'b0, 2'd0},
    {32'h0010_0004, 3'd1, 13'd9, 1'b1, 1'b1, 2'd2},
    {32'h0010_0004, 3'd1, 13'd0, 1'b0, 1'b0, 2'd0},
    {32'h0001_2000, 3'd2, 13'd7, 1'b0, 1'b1, 2'd3},
    {32'h0005_0000, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0},
    {32'h0001_2000, 3'd3, 13'd5, 1'b0, 1'b0, 2'd0}
  };
  logic [DW-1:0] exp_data [N];

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 reset hit", 64'(lk_hit), 64'd0);
    diag(2'd0);
    chk("R11 invalid tag after reset", dg_tag, '1);

    // fill: A,B (64K page),C (real),D (locked, partition 2)
    do_cmd(3'd1, 32'h0001_2000, 3'd1, 13'd5, 1'b0, 3'd0, 16'h1110, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0004_0000, 3'd1, 13'd5, 1'b0, 3'd1, 16'h2220, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0010_0000, 3'd1, 13'd0, 1'b1, 3'd0, 16'h3330, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0001_2000, 3'd2, 13'd7, 1'b0, 3'd0, 16'h4441, 1'b0, 2'd0);
    exp_data[0] = 16'h1110; exp_data[1] = 16'h2220;
    exp_data[2] = 16'h3330; exp_data[3] = 16'h4441;

    // R1 match rule over the vector table (no used update, R6)
    for (int v = 0; v < NV; v++) begin
      probe(LKV[v][51:20], LKV[v][19:17], LKV[v][16:4], LKV[v][3], 1'b0);
      chk("R1 table hit", 64'(lk_hit), 64'(LKV[v][2]));
      if (LKV[v][2]) begin
        chk("R1 table idx", 64'(lk_idx), 64'(LKV[v][1:0]));
        chk("R1 table data", 64'(lk_data), 64'(exp_data[LKV[v][1:0]]));
      end
    end

    // R4/R5: full, used={3} -> lowest unused unlocked slot 0
    do_cmd(3'd1, 32'h0002_0000, 3'd1, 13'd5, 1'b0, 3'd0, 16'h5550, 1'b0, 2'd0);
    probe(32'h0002_0010, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R4 victim slot", 64'(lk_idx), 64'd0);
    chk("R4 victim data", 64'(lk_data), 64'h5550);
    probe(32'h0001_2000, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R4 replaced miss", 64'(lk_hit), 64'd0);

    // R6: updates on slots 1 and 2 saturate, leaving only slot 2 used
    probe(32'h0004_0000, 3'd1, 13'd5, 1'b0, 1'b1);
    probe(32'h0010_0000, 3'd1, 13'd3, 1'b1, 1'b1);
    do_cmd(3'd1, 32'h0003_0000, 3'd1, 13'd5, 1'b0, 3'd0, 16'h6660, 1'b0, 2'd0);
    probe(32'h0003_0000, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R6 clear-on-saturate slot", 64'(lk_idx), 64'd0);

    // R2/R3: 64K load at idx 1 aligned to 0x30000 evicts slot 0
    do_cmd(3'd1, 32'h0003_4567, 3'd1, 13'd5, 1'b0, 3'd1, 16'h7770, 1'b1, 2'd1);
    probe(32'h0003_fff0, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R2 aligned hit", 64'(lk_hit), 64'd1);
    chk("R4 explicit idx", 64'(lk_idx), 64'd1);
    diag(2'd0);
    chk("R3 overlap evicted", dg_tag, '1);
    diag(2'd1);
    chk("R11 tag layout", dg_tag, 64'h2600_0000_0003_0005);
    chk("R11 data", 64'(dg_data), 64'h7770);

    // R8 remove context (partition 1 ctx 5)
    do_cmd(3'd3, '0, 3'd1, 13'd5, 1'b0, 3'd0, '0, 1'b0, 2'd0);
    probe(32'h0003_0000, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R8 ctx removed", 64'(lk_hit), 64'd0);
    probe(32'h0010_0000, 3'd1, 13'd0, 1'b1, 1'b0);
    chk("R8 other ctx kept", 64'(lk_hit), 64'd1);

    // R7 remove page of the real entry
    do_cmd(3'd2, 32'h0010_0000, 3'd1, 13'd0, 1'b1, 3'd0, '0, 1'b0, 2'd0);
    probe(32'h0010_0000, 3'd1, 13'd0, 1'b1, 1'b0);
    chk("R7 page removed", 64'(lk_hit), 64'd0);

    // R8 remove context takes a locked slot too
    do_cmd(3'd3, '0, 3'd2, 13'd7, 1'b0, 3'd0, '0, 1'b0, 2'd0);
    probe(32'h0001_2000, 3'd2, 13'd7, 1'b0, 1'b0);
    chk("R8 locked removed", 64'(lk_hit), 64'd0);

    // R9 remove partition spares the locked slot
    do_cmd(3'd1, 32'h1000_0000, 3'd2, 13'd1, 1'b0, 3'd0, 16'h8881, 1'b1, 2'd2);
    do_cmd(3'd1, 32'h2000_0000, 3'd2, 13'd1, 1'b0, 3'd0, 16'h9990, 1'b0, 2'd0);
    do_cmd(3'd4, '0, 3'd2, 13'd0, 1'b0, 3'd0, '0, 1'b0, 2'd0);
    probe(32'h1000_0000, 3'd2, 13'd1, 1'b0, 1'b0);
    chk("R9 locked kept", 64'(lk_hit), 64'd1);
    chk("R9 locked idx", 64'(lk_idx), 64'd2);
    probe(32'h2000_0000, 3'd2, 13'd1, 1'b0, 1'b0);
    chk("R9 unlocked removed", 64'(lk_hit), 64'd0);

    // R10 wipe
    do_cmd(3'd5, '0, 3'd0, 13'd0, 1'b0, 3'd0, '0, 1'b0, 2'd0);
    probe(32'h1000_0000, 3'd2, 13'd1, 1'b0, 1'b0);
    chk("R10 wipe miss", 64'(lk_hit), 64'd0);
    diag(2'd2);
    chk("R11 invalid data", 64'(dg_data), 64'h0000_0000_0000_ffff);

    // R12: probe and load of the same page in one cycle
    @(negedge clk);
    set_cmd(3'd1, 32'h0000_c000, 3'd1, 13'd1, 1'b0, 3'd0, 16'haaa0, 1'b1, 2'd1);
    set_lk(32'h0000_c000, 3'd1, 13'd1, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0; lk_valid = 0;
    chk("R12 probe sees old state", 64'(lk_hit), 64'd0);
    probe(32'h0000_c000, 3'd1, 13'd1, 1'b0, 1'b0);
    chk("R12 then hit", 64'(lk_idx), 64'd1);

    // R12: updating probe dropped when a load saturates used bits
    do_cmd(3'd5, '0, 3'd0, 13'd0, 1'b0, 3'd0, '0, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0000_2000, 3'd1, 13'd1, 1'b0, 3'd0, 16'h0100, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0000_4000, 3'd1, 13'd1, 1'b0, 3'd0, 16'h0200, 1'b0, 2'd0);
    do_cmd(3'd1, 32'h0000_6000, 3'd1, 13'd1, 1'b0, 3'd0, 16'h0300, 1'b0, 2'd0);
    @(negedge clk);
    set_cmd(3'd1, 32'h0000_8000, 3'd1, 13'd1, 1'b0, 3'd0, 16'h0400, 1'b0, 2'd0);
    set_lk(32'h0000_2000, 3'd1, 13'd1, 1'b0, 1'b1);
    @(negedge clk);
    cmd_valid = 0; lk_valid = 0; lk_update = 0;
    chk("R12 concurrent probe hit", 64'(lk_hit), 64'd1);
    chk("R12 concurrent probe idx", 64'(lk_idx), 64'd0);
    do_cmd(3'd1, 32'h0000_a000, 3'd1, 13'd1, 1'b0, 3'd0, 16'h0500, 1'b0, 2'd0);
    probe(32'h0000_a000, 3'd1, 13'd1, 1'b0, 1'b0);
    chk("R12 update dropped, R5 victim", 64'(lk_idx), 64'd0);
    probe(32'h0000_8000, 3'd1, 13'd1, 1'b0, 1'b0);
    chk("R4 free slot used first", 64'(lk_idx), 64'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule